// File: doc/BRIEF.md
# SMBus Idle-Low and Host-Presence Supervisor

This block sits next to an SMBus target and watches the two bus wires and an active-low host-sense input. It does not decode bus traffic. It measures how long the lines stay low, counted in ticks of a slow timebase, and acts on three thresholds.

- A short clock-low period raises a timeout flag. With the default 1 ms tick, the timeout threshold is 30 ticks, which falls inside the 25 ms to 35 ms window.
- A 2 s period with both lines low declares the bus off.
- A 5 s period with both lines low issues a single request to the offset auto-calibration logic.

Any high level on either line ends the low interval. It releases bus-off and signals that the bus is back in service.

The host-sense input is sampled once every presence period, which is 1 s by default. A low sample means a host is attached. The presence flag keeps the last sampled value until the next sample.

All three raw inputs pass through two-flop synchronizers before any logic uses them. The thresholds are parameters counted in timebase ticks. The tick is a one-clock pulse produced outside the block.

Top module: `smbus_idle_supervisor`

## Requirements
- R1: While reset is asserted and in the first cycle after it, all five outputs read 0.
- R2: Each raw input passes through two flip-flops before it is used. A raw line rising while bus-off is active clears `bus_off_o` on the third rising clock edge after the change, and not earlier.
- R3: `bus_off_o` rises one cycle after the tick on which both lines have been low together for `BUSOFF_TICKS` ticks.
- R4: `bus_off_o` falls in the first cycle in which the synchronized clock line or the synchronized data line is high. In that same cycle, `bus_resume_o` is a single-cycle pulse.
- R5: `cal_req_o` is a single-cycle pulse. It comes one cycle after the `CAL_TICKS`-th tick of an uninterrupted both-low interval, and it is issued at most once per interval.
- R6: A high level of either line, even for one cycle, restarts the both-low count from zero.
- R7: `clk_tmo_o` rises one cycle after the `TMO_TICKS`-th tick of an uninterrupted clock-low period. It falls when the clock line is high. The data line alone has no effect on it.
- R8: The presence sample is taken on every `PRES_TICKS`-th tick. At a sample, `host_present_o` becomes 1 if the synchronized host-sense input is low and 0 if it is high. Between samples, the flag holds its value.
- R9: A calibration request is only ever issued while bus-off is active, because the parameters must satisfy `CAL_TICKS` > `BUSOFF_TICKS` > `TMO_TICKS`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle timebase tick (1 ms by default) |
| scl_raw_i | input | 1 | Raw SMBus clock level |
| sda_raw_i | input | 1 | Raw SMBus data level |
| host_sense_n_i | input | 1 | Raw host-sense level, low means a host is attached |
| bus_off_o | output | 1 | Both lines have been held low beyond the bus-off threshold |
| cal_req_o | output | 1 | Single-cycle offset auto-calibration request |
| clk_tmo_o | output | 1 | The clock line has been low beyond the timeout threshold |
| host_present_o | output | 1 | Last sampled host presence |
| bus_resume_o | output | 1 | Single-cycle pulse when bus-off ends |

## Verification
The bench drives a long clock-low period with the data line high, and a long data-low period with the clock line high. A design that merged the two counters would then raise timeout or bus-off from the wrong line. The bench also interrupts a both-low interval with a one-cycle high glitch. A design that paused the count instead of restarting it would declare bus-off early. A single both-low interval that runs well past the calibration threshold must produce exactly one request. A design that re-armed after saturating would issue a stream of requests. Bus-off is released once by the clock line and once by the data line alone, and each release is timed to the exact cycle. Toggling the host-sense input between samples must leave the presence flag unchanged.

// File: rtl/smbmon_pkg.sv
package smbmon_pkg;

  // Width needed to hold values 0..n inclusive.
  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

  // True on the tick that moves a counter from mark-1 to mark.
  function automatic logic at_mark(input logic step, input int unsigned cnt,
                                   input int unsigned mark);
    return step && (cnt == mark - 1);
  endfunction

endpackage

// File: rtl/smbmon_sync.sv
module smbmon_sync #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] lvl_o
);
  logic [W-1:0] meta_q;

  // Idle level of every watched input is high (released bus, no host).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      lvl_o  <= '1;
    end else begin
      meta_q <= raw_i;
      lvl_o  <= meta_q;
    end
  end
endmodule

// File: rtl/smbmon_low_timer.sv
module smbmon_low_timer #(
  parameter int unsigned SAT = 8,
  parameter int unsigned CW  = smbmon_pkg::cnt_w(SAT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          low_i,
  input  logic          tick_i,
  output logic [CW-1:0] cnt_o,
  output logic          step_o
);
  // Counts ticks of an uninterrupted low period, saturating at SAT.
  assign step_o = low_i && tick_i && (cnt_o != CW'(SAT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_o <= '0;
    else if (!low_i) cnt_o <= '0;
    else if (step_o) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/smbmon_presence.sv
module smbmon_presence #(
  parameter int unsigned PERIOD = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic sense_n_i,
  output logic sample_o,
  output logic present_o
);
  localparam int unsigned PW = smbmon_pkg::cnt_w(PERIOD);

  logic [PW-1:0] phase_q;

  assign sample_o = tick_i && (phase_q == PW'(PERIOD - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= '0;
      present_o <= 1'b0;
    end else begin
      if (sample_o)    phase_q <= '0;
      else if (tick_i) phase_q <= phase_q + 1'b1;
      if (sample_o)    present_o <= ~sense_n_i;
    end
  end
endmodule

// File: rtl/smbus_idle_supervisor.sv
module smbus_idle_supervisor #(
  parameter int unsigned TMO_TICKS    = 30,
  parameter int unsigned BUSOFF_TICKS = 2000,
  parameter int unsigned CAL_TICKS    = 5000,
  parameter int unsigned PRES_TICKS   = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic scl_raw_i,
  input  logic sda_raw_i,
  input  logic host_sense_n_i,
  output logic bus_off_o,
  output logic cal_req_o,
  output logic clk_tmo_o,
  output logic host_present_o,
  output logic bus_resume_o
);
  import smbmon_pkg::*;

  localparam int unsigned LW = cnt_w(CAL_TICKS);
  localparam int unsigned TW = cnt_w(TMO_TICKS);

  logic [2:0]    lvl;
  logic          scl_s, sda_s, sense_s;
  logic          both_low;
  logic [LW-1:0] low_cnt;
  logic          low_step;
  logic [TW-1:0] clk_cnt;
  logic          clk_step;
  logic          busoff_evt, cal_evt, tmo_evt, release_evt, pres_evt;

  smbmon_sync #(.W(3)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .raw_i({host_sense_n_i, sda_raw_i, scl_raw_i}),
    .lvl_o(lvl)
  );
  assign scl_s   = lvl[0];
  assign sda_s   = lvl[1];
  assign sense_s = lvl[2];

  assign both_low = ~scl_s & ~sda_s;

  smbmon_low_timer #(.SAT(CAL_TICKS), .CW(LW)) u_both_low (
    .clk(clk), .rst_n(rst_n), .low_i(both_low), .tick_i(tick_i),
    .cnt_o(low_cnt), .step_o(low_step)
  );

  smbmon_low_timer #(.SAT(TMO_TICKS), .CW(TW)) u_clk_low (
    .clk(clk), .rst_n(rst_n), .low_i(~scl_s), .tick_i(tick_i),
    .cnt_o(clk_cnt), .step_o(clk_step)
  );

  smbmon_presence #(.PERIOD(PRES_TICKS)) u_pres (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .sense_n_i(sense_s),
    .sample_o(pres_evt), .present_o(host_present_o)
  );

  // Named events, shared by the flag logic and the checker.
  assign busoff_evt  = at_mark(low_step, 32'(low_cnt), BUSOFF_TICKS);
  assign cal_evt     = at_mark(low_step, 32'(low_cnt), CAL_TICKS);
  assign tmo_evt     = at_mark(clk_step, 32'(clk_cnt), TMO_TICKS);
  assign release_evt = bus_off_o && !both_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_off_o    <= 1'b0;
      cal_req_o    <= 1'b0;
      clk_tmo_o    <= 1'b0;
      bus_resume_o <= 1'b0;
    end else begin
      bus_resume_o <= release_evt;
      cal_req_o    <= cal_evt;
      if (!both_low)       bus_off_o <= 1'b0;
      else if (busoff_evt) bus_off_o <= 1'b1;
      if (scl_s)           clk_tmo_o <= 1'b0;
      else if (tmo_evt)    clk_tmo_o <= 1'b1;
    end
  end
endmodule

// File: rtl/smbus_idle_supervisor_chk.sv
module smbus_idle_supervisor_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_off,
  input logic cal_req,
  input logic clk_tmo,
  input logic present,
  input logic resume,
  input logic sample
);
  // R4: ending bus-off and the resume pulse coincide
  assert_resume_on_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_off) |-> resume);
  assert_resume_only_when_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
    resume |-> !bus_off);
  // R5: calibration request lasts one cycle
  assert_cal_single_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cal_req |=> !cal_req);
  // R9: calibration request only during bus-off
  assert_cal_inside_busoff_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cal_req |-> bus_off);
  // R3: bus-off implies the clock line already timed out
  assert_busoff_after_tmo_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_off) |-> clk_tmo);
  // R8: presence flag moves only after a sampling tick
  assert_present_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sample |=> $stable(present));
endmodule

bind smbus_idle_supervisor smbus_idle_supervisor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_off(bus_off_o), .cal_req(cal_req_o),
  .clk_tmo(clk_tmo_o), .present(host_present_o), .resume(bus_resume_o),
  .sample(pres_evt)
);

// File: tb/smbus_idle_supervisor_tb_top.sv
module smbus_idle_supervisor_tb_top;
  localparam int TMO = 5, BOFF = 12, CAL = 20, PRES = 8;
  localparam int TICK_DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 1'b0;
  logic scl = 1'b1, sda = 1'b1, sense_n = 1'b1;
  logic bus_off, cal_req, clk_tmo, present, resume;

  int checks = 0, errors = 0, cyc = 0, cal_seen = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  smbus_idle_supervisor #(.TMO_TICKS(TMO), .BUSOFF_TICKS(BOFF),
                          .CAL_TICKS(CAL), .PRES_TICKS(PRES)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .scl_raw_i(scl),
    .sda_raw_i(sda), .host_sense_n_i(sense_n), .bus_off_o(bus_off),
    .cal_req_o(cal_req), .clk_tmo_o(clk_tmo), .host_present_o(present),
    .bus_resume_o(resume)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // Timebase: one tick every TICK_DIV cycles, driven away from the active edge.
  always @(negedge clk) begin
    cyc++;
    tick_i = (cyc % TICK_DIV == 0);
    if (cal_req) cal_seen++;
  end

  // Behavioural reference: line histories plus elapsed low-time in ticks.
  int hc[2], hd[2], hp[2];
  int low_ticks, clk_ticks, phase;
  bit m_off, m_cal, m_tmo, m_pres, m_res;

  always @(posedge clk) begin
    if (!rst_n) begin
      hc = '{1, 1}; hd = '{1, 1}; hp = '{1, 1};
      low_ticks = 0; clk_ticks = 0; phase = 0;
      m_off = 0; m_cal = 0; m_tmo = 0; m_pres = 0; m_res = 0;
    end else begin
      bit both;
      both  = (hc[1] == 0) && (hd[1] == 0);
      m_res = m_off && !both;
      m_cal = both && tick_i && (low_ticks == CAL - 1);
      if (!both) begin
        m_off = 0; low_ticks = 0;
      end else if (tick_i && low_ticks < CAL) begin
        low_ticks++;
        if (low_ticks == BOFF) m_off = 1;
      end
      if (hc[1] != 0) begin
        m_tmo = 0; clk_ticks = 0;
      end else if (tick_i && clk_ticks < TMO) begin
        clk_ticks++;
        if (clk_ticks == TMO) m_tmo = 1;
      end
      if (tick_i) begin
        if (phase == PRES - 1) begin phase = 0; m_pres = (hp[1] == 0); end
        else phase++;
      end
      hc[1] = hc[0]; hc[0] = int'(scl);
      hd[1] = hd[0]; hd[0] = int'(sda);
      hp[1] = hp[0]; hp[0] = int'(sense_n);
    end
  end

  // Every-cycle comparison against the reference.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3 bus_off", bus_off, m_off);
      chk("R5 cal_req", cal_req, m_cal);
      chk("R7 clk_tmo", clk_tmo, m_tmo);
      chk("R8 present", present, m_pres);
      chk("R4 resume", resume, m_res);
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    wait_cyc(3);
    chk("R1 bus_off in reset", bus_off, 1'b0);
    chk("R1 cal in reset", cal_req, 1'b0);
    chk("R1 tmo in reset", clk_tmo, 1'b0);
    chk("R1 present in reset", present, 1'b0);
    chk("R1 resume in reset", resume, 1'b0);
    rst_n = 1'b1;
    wait_cyc(1);
    chk("R1 present after reset", present, 1'b0);
    chk("R1 bus_off after reset", bus_off, 1'b0);

    // R7: clock low alone times out but never reaches bus-off
    scl = 0; wait_cyc(40 * TICK_DIV);
    chk("R7 tmo on clock low", clk_tmo, 1'b1);
    chk("R7 no bus_off with data high", bus_off, 1'b0);
    scl = 1; wait_cyc(4);
    chk("R7 tmo cleared by clock high", clk_tmo, 1'b0);

    // R7: data low alone has no effect on timeout or bus-off
    sda = 0; wait_cyc(40 * TICK_DIV);
    chk("R7 data alone no tmo", clk_tmo, 1'b0);
    chk("R3 data alone no bus_off", bus_off, 1'b0);
    sda = 1; wait_cyc(4);

    // R6: a one-cycle glitch restarts the both-low count
    scl = 0; sda = 0; wait_cyc(8 * TICK_DIV);
    sda = 1; wait_cyc(1); sda = 0;
    wait_cyc(9 * TICK_DIV);
    chk("R6 glitch restarted count", bus_off, 1'b0);
    scl = 1; sda = 1; wait_cyc(6);

    // R3, R5: long both-low interval, release by clock line
    cal_seen = 0;
    scl = 0; sda = 0; wait_cyc(30 * TICK_DIV);
    chk("R3 bus_off after threshold", bus_off, 1'b1);
    chk("R5 exactly one cal request", (cal_seen == 1), 1'b1);
    scl = 1;
    wait_cyc(2);
    chk("R2 bus_off held two edges", bus_off, 1'b1);
    wait_cyc(1);
    chk("R2 bus_off cleared third edge", bus_off, 1'b0);
    chk("R4 resume pulse on release", resume, 1'b1);
    wait_cyc(1);
    chk("R4 resume is one cycle", resume, 1'b0);
    wait_cyc(6);

    // R4: release by the data line alone
    scl = 0; wait_cyc(16 * TICK_DIV);
    chk("R3 bus_off again", bus_off, 1'b1);
    chk("R9 cal not yet", cal_req, 1'b0);
    sda = 1; wait_cyc(3);
    chk("R4 data high clears bus_off", bus_off, 1'b0);
    chk("R4 resume on data release", resume, 1'b1);
    scl = 1; wait_cyc(6);

    // R8: presence sampling and holding
    sense_n = 0; wait_cyc((PRES + 3) * TICK_DIV);
    chk("R8 host present after sample", present, 1'b1);
    for (int k = 0; k < 6; k++) begin
      sense_n = 1; wait_cyc(2); sense_n = 0; wait_cyc(9);
    end
    chk("R8 short highs absorbed", present, 1'b1);
    sense_n = 1; wait_cyc((PRES + 3) * TICK_DIV);
    chk("R8 host absent after sample", present, 1'b0);

    wait_cyc(10);
    finish_run();
  end

  initial begin
    wait_cyc(20000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end
endmodule